// File: doc/BRIEF.md
# Mode-Dependent Parallel Port Byte FIFO

This block is the byte queue that sits behind the single data-FIFO register of a parallel port. A 3-bit port mode selects how the queue is used. It can be a forward-only queue that the host fills and the port drains. It can be a bidirectional queue whose direction follows a control bit. It can be a test queue that the host both writes and reads with no port traffic. In the remaining modes the queue is idle. The host side has single-cycle write and read strobes, a small control byte that carries the direction bit, and full, empty and service-interrupt status outputs.

The port side has two simple byte channels. The outbound channel offers the head byte with a valid/ready pair whenever the mode drains toward the port. The inbound channel accepts bytes with a valid/ready pair whenever the mode fills from the port. In test mode the queue never stalls. A write to a full queue is dropped, and a read of an empty queue returns the last byte read. The service interrupt is a level. In the outbound direction it signals a low fill level, and in the inbound direction it signals a high fill level. Any change of the mode field empties the queue.

Top module: `lpt_mode_fifo`

## Requirements
- R1: After reset the queue is empty (empty_o=1, full_o=0), host_rdata_o=00h, ctl_rdata_o=00h, and neither port channel is active.
- R2: A control write stores bits 4:0 and the direction bit at bit 5, which take effect from the next cycle. Bits 7:6 always read back as 0.
- R3: In modes 000 and 010 the direction bit is ignored and the port acts as output. In mode 010 host writes are queued and offered in order on the outbound channel, and host reads are ignored. In mode 000 the queue takes no host traffic.
- R4: In mode 011 with direction 0, host writes are queued and drained on the outbound channel. With direction 1, inbound bytes fill the queue and each host read updates host_rdata_o with the oldest byte one cycle later.
- R5: In mode 110 the host may write and read in either direction, and per_out_valid_o and per_in_ready_o stay 0.
- R6: A host write to a full queue is discarded. The queue contents and the full flag are unchanged.
- R7: A host read of an empty queue leaves host_rdata_o at the last byte read.
- R8: full_o is 1 exactly when 16 bytes are held (DEPTH), and empty_o is 1 exactly when none are held, including after dropped writes and repeated reads.
- R9: In modes 010, 011 and 110, svc_intr_o is 1 when the effective direction is 0 and occupancy is at most WR_THR, or when the direction is 1 and occupancy is at least RD_THR. In all other modes it is 0.
- R10: A cycle in which mode_i differs from the previous cycle's mode ignores all transfers. At the next edge it empties the queue and clears host_rdata_o to 00h.
- R11: per_out_valid_o is 1 only in a draining mode/direction with the queue non-empty. per_in_ready_o is 1 only in mode 011 with direction 1 and the queue not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 3 | Port mode field |
| ctl_wr_i | input | 1 | Control byte write strobe |
| ctl_wdata_i | input | 8 | Control byte write data (bit 5 = direction) |
| ctl_rdata_o | output | 8 | Control byte read-back |
| host_wr_i | input | 1 | Host write strobe to the data queue |
| host_wdata_i | input | 8 | Host write byte |
| host_rd_i | input | 1 | Host read strobe from the data queue |
| host_rdata_o | output | 8 | Last byte read from the queue |
| full_o | output | 1 | Queue full |
| empty_o | output | 1 | Queue empty |
| svc_intr_o | output | 1 | Threshold service request level |
| per_out_valid_o | output | 1 | Outbound byte available to the port |
| per_out_ready_i | input | 1 | Port accepts the outbound byte |
| per_out_data_o | output | 8 | Outbound byte (queue head) |
| per_in_valid_i | input | 1 | Port offers an inbound byte |
| per_in_ready_o | output | 1 | Queue accepts the inbound byte |
| per_in_data_i | input | 8 | Inbound byte |

## Verification
The assertions assume that the host strobes and the port's valid and ready inputs are clean levels sampled at the rising edge. They also assume that the port never expects a transfer in the cycle in which the mode field moves. The stimulus changes every input half a cycle away from the active edge. It changes the mode only rarely, with a dedicated cycle, so that flushes, dropped writes and repeated reads each occur on their own and also next to live traffic. A bench model built from the requirements predicts every output for each drive pattern.

// File: rtl/lpt_fifo_pkg.sv
package lpt_fifo_pkg;

  typedef enum logic [2:0] {
    PM_COMPAT   = 3'b000,
    PM_BYTE     = 3'b001,
    PM_FIFO_FWD = 3'b010,
    PM_EXT      = 3'b011,
    PM_ADDR     = 3'b100,
    PM_RSV      = 3'b101,
    PM_TEST     = 3'b110,
    PM_CFG      = 3'b111
  } port_mode_e;

  localparam int CTL_DIR_BIT = 5;

  typedef struct packed {
    logic active;
    logic eff_dir;
    logic drain;
    logic fill;
    logic host_wr_en;
    logic host_rd_en;
    logic test;
  } mode_ctl_t;

  // Mode/direction decode: which sides may push and pop the queue.
  function automatic mode_ctl_t decode_mode(logic [2:0] m, logic dir);
    mode_ctl_t c;
    c            = '0;
    c.test       = (m == PM_TEST);
    c.active     = (m == PM_FIFO_FWD) || (m == PM_EXT) || (m == PM_TEST);
    c.eff_dir    = ((m == PM_COMPAT) || (m == PM_FIFO_FWD)) ? 1'b0 : dir;
    c.drain      = (m == PM_FIFO_FWD) || ((m == PM_EXT) && !dir);
    c.fill       = (m == PM_EXT) && dir;
    c.host_wr_en = c.drain || c.test;
    c.host_rd_en = c.fill || c.test;
    return c;
  endfunction

  // Service level: low water toward the port, high water from the port.
  function automatic logic svc_level(int unsigned occ, logic act, logic dir,
                                     int unsigned wthr, int unsigned rthr);
    if (!act) return 1'b0;
    return dir ? (occ >= rthr) : (occ <= wthr);
  endfunction

endpackage

// File: rtl/lpt_fifo_store.sv
module lpt_fifo_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (push_i && !flush_i) mem[wr_ptr] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush_i) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push_i) wr_ptr <= wr_ptr + 1'b1;
      if (pop_i)  rd_ptr <= rd_ptr + 1'b1;
      unique case ({push_i, pop_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_o  = mem[rd_ptr];
  assign count_o = count_q;
  assign full_o  = (count_q == FULL_CNT);
  assign empty_o = (count_q == '0);

endmodule

// File: rtl/lpt_mode_decode.sv
module lpt_mode_decode
  import lpt_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_i,
  input  logic       dir_i,
  output mode_ctl_t  ctl_o,
  output logic       mode_chg_o
);

  logic [2:0] mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= PM_COMPAT;
    else        mode_q <= mode_i;
  end

  assign mode_chg_o = (mode_i != mode_q);
  assign ctl_o      = decode_mode(mode_i, dir_i);

endmodule

// File: rtl/lpt_ctl_reg.sv
module lpt_ctl_reg
  import lpt_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       dir_o
);

  logic [5:0] ctl_q;
  logic [1:0] ctl_unused_hi;

  assign ctl_unused_hi = wdata_i[7:6];

  always_ff @(posedge clk) begin
    if (!rst_n)    ctl_q <= '0;
    else if (wr_i) ctl_q <= wdata_i[5:0];
  end

  assign rdata_o = {2'b00, ctl_q};
  assign dir_o   = ctl_q[CTL_DIR_BIT];

endmodule

// File: rtl/lpt_svc_irq.sv
module lpt_svc_irq
  import lpt_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WR_THR = 8,
  parameter int RD_THR = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] count_i,
  input  logic          active_i,
  input  logic          eff_dir_i,
  output logic          svc_o
);

  assign svc_o = svc_level(32'(count_i), active_i, eff_dir_i,
                           WR_THR, RD_THR);

endmodule

// File: rtl/lpt_mode_fifo.sv
module lpt_mode_fifo
  import lpt_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WR_THR = 8,
  parameter int RD_THR = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_i,
  input  logic       ctl_wr_i,
  input  logic [7:0] ctl_wdata_i,
  output logic [7:0] ctl_rdata_o,
  input  logic       host_wr_i,
  input  logic [7:0] host_wdata_i,
  input  logic       host_rd_i,
  output logic [7:0] host_rdata_o,
  output logic       full_o,
  output logic       empty_o,
  output logic       svc_intr_o,
  output logic       per_out_valid_o,
  input  logic       per_out_ready_i,
  output logic [7:0] per_out_data_o,
  input  logic       per_in_valid_i,
  output logic       per_in_ready_o,
  input  logic [7:0] per_in_data_i
);

  mode_ctl_t     mctl;
  logic          dir;
  logic          mode_chg;
  logic [7:0]    head;
  logic [CW-1:0] count;

  // Named internal events, also watched by the checker.
  logic push_host, push_per, pop_host, pop_per;
  logic push_any, pop_any;
  logic wr_dropped, rd_repeat;
  logic [7:0] push_data;
  logic [7:0] last_rd_q;

  lpt_ctl_reg u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (ctl_wr_i),
    .wdata_i (ctl_wdata_i),
    .rdata_o (ctl_rdata_o),
    .dir_o   (dir)
  );

  lpt_mode_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .dir_i      (dir),
    .ctl_o      (mctl),
    .mode_chg_o (mode_chg)
  );

  assign push_host  = host_wr_i && mctl.host_wr_en && !mode_chg && !full_o;
  assign wr_dropped = host_wr_i && mctl.host_wr_en && !mode_chg &&  full_o;
  assign pop_host   = host_rd_i && mctl.host_rd_en && !mode_chg && !empty_o;
  assign rd_repeat  = host_rd_i && mctl.host_rd_en && !mode_chg &&  empty_o;

  assign per_out_valid_o = mctl.drain && !mode_chg && !empty_o;
  assign per_in_ready_o  = mctl.fill  && !mode_chg && !full_o;
  assign per_out_data_o  = head;

  assign pop_per   = per_out_valid_o && per_out_ready_i;
  assign push_per  = per_in_valid_i  && per_in_ready_o;
  assign push_any  = push_host || push_per;
  assign pop_any   = pop_host  || pop_per;
  assign push_data = push_per ? per_in_data_i : host_wdata_i;

  lpt_fifo_store #(.DEPTH(DEPTH), .DW(8)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (mode_chg),
    .push_i      (push_any),
    .push_data_i (push_data),
    .pop_i       (pop_any),
    .head_o      (head),
    .count_o     (count),
    .full_o      (full_o),
    .empty_o     (empty_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || mode_chg) last_rd_q <= 8'h00;
    else if (pop_host)      last_rd_q <= head;
  end
  assign host_rdata_o = last_rd_q;

  lpt_svc_irq #(.DEPTH(DEPTH), .WR_THR(WR_THR), .RD_THR(RD_THR)) u_svc (
    .count_i   (count),
    .active_i  (mctl.active),
    .eff_dir_i (mctl.eff_dir),
    .svc_o     (svc_intr_o)
  );

endmodule

// File: rtl/lpt_mode_fifo_chk.sv
module lpt_mode_fifo_chk #(
  parameter int DEPTH = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_i,
  input logic       full_o,
  input logic       empty_o,
  input logic [7:0] host_rdata_o,
  input logic       svc_intr_o,
  input logic       per_out_valid_o,
  input logic       per_in_ready_o,
  input logic       mode_chg,
  input logic       wr_dropped,
  input logic       rd_repeat,
  input logic       pop_any
);

  logic fifo_mode;
  assign fifo_mode = (mode_i == 3'b010) || (mode_i == 3'b011) || (mode_i == 3'b110);

  p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_o && empty_o));

  p_drop_keeps_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dropped && !pop_any) |=> full_o);

  p_repeat_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_repeat |=> $stable(host_rdata_o));

  p_test_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'b110) |-> (!per_out_valid_o && !per_in_ready_o));

  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (empty_o && host_rdata_o == 8'h00));

  p_in_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !per_in_ready_o);

  p_out_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> !per_out_valid_o);

  p_svc_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |-> !svc_intr_o);

  p_out_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == 3'b000) || (mode_i == 3'b010)) |-> !per_in_ready_o);

endmodule

bind lpt_mode_fifo lpt_mode_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .mode_i          (mode_i),
  .full_o          (full_o),
  .empty_o         (empty_o),
  .host_rdata_o    (host_rdata_o),
  .svc_intr_o      (svc_intr_o),
  .per_out_valid_o (per_out_valid_o),
  .per_in_ready_o  (per_in_ready_o),
  .mode_chg        (mode_chg),
  .wr_dropped      (wr_dropped),
  .rd_repeat       (rd_repeat),
  .pop_any         (pop_any)
);

// File: tb/lpt_mode_fifo_tb_top.sv
module lpt_mode_fifo_tb_top;

  localparam int DEPTH = 16;
  localparam int WTHR  = 8;
  localparam int RTHR  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [2:0] mode_i = '0;
  logic       ctl_wr_i = 0, host_wr_i = 0, host_rd_i = 0;
  logic [7:0] ctl_wdata_i = '0, host_wdata_i = '0, per_in_data_i = '0;
  logic       per_out_ready_i = 0, per_in_valid_i = 0;
  logic [7:0] ctl_rdata_o, host_rdata_o, per_out_data_o;
  logic       full_o, empty_o, svc_intr_o, per_out_valid_o, per_in_ready_o;

  lpt_mode_fifo #(.DEPTH(DEPTH), .WR_THR(WTHR), .RD_THR(RTHR)) dut_i (.*);

  int n_tests = 0, n_fail = 0;
  string ctx = "R1";
  logic [7:0] q[$];
  logic [7:0] m_last = 8'h00;
  logic [2:0] m_prev = 3'b000;
  logic [5:0] m_ctl  = 6'h00;

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL [%s] %s: got %0h exp %0h", ctx, what, act, exp);
    end
  endtask

  function automatic logic exp_svc(logic [2:0] m, logic d, int occ);
    logic act, ed;
    act = (m == 3'b010) || (m == 3'b011) || (m == 3'b110);
    ed  = (m == 3'b000 || m == 3'b010) ? 1'b0 : d;
    if (!act) return 1'b0;
    if (ed) return occ >= RTHR;
    return occ <= WTHR;
  endfunction

  task automatic step(input logic [2:0] m, input logic wr, input logic [7:0] wd,
                      input logic rd, input logic prdy, input logic pval,
                      input logic [7:0] pd, input logic cw, input logic [7:0] cd);
    logic d, chg, drain, fill, test, wr_ok, rd_ok, pov, pir;
    int sz;
    @(negedge clk);
    mode_i = m; host_wr_i = wr; host_wdata_i = wd; host_rd_i = rd;
    per_out_ready_i = prdy; per_in_valid_i = pval; per_in_data_i = pd;
    ctl_wr_i = cw; ctl_wdata_i = cd;
    #1;
    d     = m_ctl[5];
    sz    = q.size();
    chg   = (m != m_prev);
    test  = (m == 3'b110);
    drain = (m == 3'b010) || (m == 3'b011 && !d);
    fill  = (m == 3'b011 && d);
    wr_ok = !chg && wr && (drain || test);
    rd_ok = !chg && rd && (fill || test);
    pov   = drain && !chg && sz > 0;
    pir   = fill && !chg && sz < DEPTH;
    check("R8 full",  32'(full_o),  32'(sz == DEPTH));
    check("R8 empty", 32'(empty_o), 32'(sz == 0));
    check("R7 rdata", 32'(host_rdata_o), 32'(m_last));
    check("R9 svc",   32'(svc_intr_o), 32'(exp_svc(m, d, sz)));
    check("R11 out_valid", 32'(per_out_valid_o), 32'(pov));
    check("R11 in_ready",  32'(per_in_ready_o),  32'(pir));
    check("R2 ctl_rdata",  32'(ctl_rdata_o), {24'h0, 2'b00, m_ctl});
    if (pov) check("R4 out_data", 32'(per_out_data_o), 32'(q[0]));
    // model update for the coming edge
    if (chg) begin
      q.delete();
      m_last = 8'h00;
    end else begin
      if (rd_ok && sz > 0) m_last = q.pop_front();
      if (pov && prdy) void'(q.pop_front());
      if (wr_ok && sz < DEPTH) q.push_back(wd);
      if (pir && pval) q.push_back(pd);
    end
    if (cw) m_ctl = cd[5:0];
    m_prev = m;
  endtask

  task automatic idle(input logic [2:0] m);
    step(m, 0, 8'h00, 0, 0, 0, 8'h00, 0, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL [watchdog] run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5a17));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 empty", 32'(empty_o), 1);
    check("R1 full",  32'(full_o), 0);
    check("R1 rdata", 32'(host_rdata_o), 0);
    check("R1 ctl",   32'(ctl_rdata_o), 0);
    check("R1 out_valid", 32'(per_out_valid_o), 0);
    rst_n = 1'b1;
    idle(3'b000);

    // R2: write all ones, upper bits must read 0
    ctx = "R2";
    step(3'b000, 0, 0, 0, 0, 0, 0, 1, 8'hFF);
    idle(3'b000);
    check("R2 hi bits", 32'(ctl_rdata_o), 32'h3F);

    // R5/R6/R8: test mode, 17 writes with direction 1
    ctx = "R6";
    idle(3'b110);
    for (int i = 0; i < 17; i++) step(3'b110, 1, 8'h10 + 8'(i), 0, 1, 1, 8'hEE, 0, 0);
    idle(3'b110);
    check("R6 full after extra write", 32'(full_o), 1);
    ctx = "R5";
    step(3'b110, 0, 0, 0, 0, 0, 0, 1, 8'h00);     // direction 0, still test
    for (int i = 0; i < 16; i++) step(3'b110, 0, 0, 1, 1, 1, 8'hEE, 0, 0);
    idle(3'b110);
    check("R6 last stored byte", 32'(host_rdata_o), 32'h1F);
    ctx = "R7";
    step(3'b110, 0, 0, 1, 0, 0, 0, 0, 0);
    step(3'b110, 0, 0, 1, 0, 0, 0, 0, 0);
    idle(3'b110);
    check("R7 repeated byte", 32'(host_rdata_o), 32'h1F);

    // R3: mode 010 with direction 1 still drains outward
    ctx = "R3";
    step(3'b010, 0, 0, 0, 0, 0, 0, 1, 8'h20);
    for (int i = 0; i < 4; i++) step(3'b010, 1, 8'hA0 + 8'(i), 1, 0, 1, 8'h55, 0, 0);
    check("R3 in_ready off", 32'(per_in_ready_o), 0);
    for (int i = 0; i < 5; i++) step(3'b010, 0, 0, 0, 1, 0, 0, 0, 0);
    ctx = "R3 compat";
    step(3'b000, 1, 8'h77, 0, 0, 0, 0, 0, 0);
    step(3'b000, 1, 8'h78, 0, 0, 0, 0, 0, 0);
    idle(3'b000);
    check("R3 compat ignores writes", 32'(empty_o), 1);

    // R4: mode 011 direction 1 fills from the port
    ctx = "R4";
    step(3'b011, 0, 0, 0, 0, 0, 0, 1, 8'h20);
    for (int i = 0; i < 10; i++) step(3'b011, 0, 0, 0, 0, 1, 8'hC0 + 8'(i), 0, 0);
    for (int i = 0; i < 12; i++) step(3'b011, 0, 0, 1, 0, 0, 0, 0, 0);
    // direction 0 drains
    step(3'b011, 0, 0, 0, 0, 0, 0, 1, 8'h00);
    for (int i = 0; i < 6; i++) step(3'b011, 1, 8'h30 + 8'(i), 0, i[0], 0, 0, 0, 0);
    // R9: thresholds in test mode with both directions
    ctx = "R9";
    for (int i = 0; i < 18; i++) step(3'b110, 1, 8'(i), 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 18; i++) step(3'b110, 0, 0, 1, 0, 0, 0, i == 9, 8'h20);

    // R10: flush on mode change
    ctx = "R10";
    for (int i = 0; i < 5; i++) step(3'b110, 1, 8'h90 + 8'(i), i == 4, 0, 0, 0, 0, 0);
    idle(3'b110);
    step(3'b011, 1, 8'h01, 1, 1, 1, 8'h02, 0, 0);
    idle(3'b011);
    check("R10 flushed", 32'(empty_o), 1);
    check("R10 rdata cleared", 32'(host_rdata_o), 0);

    // constrained random mix
    ctx = "RND";
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] m;
      m = m_prev;
      if ($urandom_range(39) == 0) begin
        case ($urandom_range(5))
          0: m = 3'b000; 1: m = 3'b010; 2, 3: m = 3'b011;
          4: m = 3'b110; default: m = 3'($urandom_range(7));
        endcase
      end
      step(m, 1'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 8'($urandom), $urandom_range(29) == 0, 8'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule